// File: doc/BRIEF.md
# Exception Restart Address Unit

This unit keeps the program-counter bookkeeping that a processor core needs around exceptions and warm resets. When an exception strobe arrives, it records a restart address. That address is the current PC, stepped back to the branch if the faulting instruction sits in a delay slot. The compressed-ISA mode is folded into bit 0 of the recorded address. A warm-reset strobe records an error return address with the same step-back, and fetch is then redirected to a per-core boot base register.

The unit also produces the next fetch PC for two other redirections. On a jump, the target's bit 0 is split off as the new compressed-mode flag. On a return from exception, fetch resumes at the recorded restart address and a one-cycle pulse tells the pipeline to drop its delay-slot state.

Top module: `restart_addr_unit`

## Requirements
- R1: During and right after hardware reset (`rstN` low), `fetchPc` equals the boot address 0xBFC00000 sign-extended to `AW` bits. `modeOut`, `slotClr`, `restartPc` and `errorPc` are all zero.
- R2: An `excStrobe` with `dlySlot` low records `restartPc` = `pcIn` with bit 0 replaced by `isaMode`. The incoming bit 0 of `pcIn` is ignored.
- R3: An `excStrobe` with `dlySlot` high records that same tagged value minus 2 when `brShort` is high, and minus 4 when it is low. `brShort` has no effect when `dlySlot` is low.
- R4: `dlySlot`, `brShort`, `isaMode` and `pcIn` are sampled on the strobe's clock edge, and the new `restartPc` is visible from the next cycle. Without a strobe, `restartPc` and `errorPc` hold their values.
- R5: A `softRst` strobe records `errorPc` = `pcIn` with bit 0 cleared, minus the same delay-slot step (0, 2 or 4). It also sets `fetchPc` to the boot base register with bit 0 cleared, and clears `modeOut`.
- R6: `baseWe` loads `baseData` into the boot base register. A `softRst` uses the base value held before any write in the same cycle.
- R7: A `jmpStrobe` sets `fetchPc` to `jmpTarget` with bit 0 cleared, and `modeOut` to `jmpTarget[0]`.
- R8: An `eretStrobe` sets `fetchPc` to the recorded `restartPc` with bit 0 cleared, and `modeOut` to `restartPc[0]`. It pulses `slotClr` high for exactly the next cycle. It uses the `restartPc` held before any capture in the same cycle.
- R9: For the fetch redirection, `softRst` has priority over `eretStrobe`, which has priority over `jmpStrobe`. With none of the three, `fetchPc` and `modeOut` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| pcIn | input | AW | PC of the instruction taking the event |
| dlySlot | input | 1 | Instruction is in a branch delay slot |
| brShort | input | 1 | The owning branch is a 16-bit encoding |
| isaMode | input | 1 | Current compressed-ISA mode |
| excStrobe | input | 1 | Exception event: record restart address |
| softRst | input | 1 | Warm reset event: record error address, fetch from base |
| eretStrobe | input | 1 | Resume from the recorded restart address |
| jmpStrobe | input | 1 | Load a jump target |
| jmpTarget | input | AW | Jump target, bit 0 selects the compressed mode |
| baseWe | input | 1 | Write strobe of the boot base register |
| baseData | input | AW | New boot base value |
| restartPc | output | AW | Recorded restart address with mode in bit 0 |
| errorPc | output | AW | Recorded warm-reset return address |
| fetchPc | output | AW | Next fetch PC, always even |
| modeOut | output | 1 | Compressed-mode flag for fetch |
| slotClr | output | 1 | One-cycle pulse that clears delay-slot state |

## Verification
The checker watches these properties on every cycle:
- `fetchPc` stays even.
- A jump moves the target's bit 0 into the mode flag.
- A warm reset clears the mode.
- `slotClr` rises only after a resume.
- The recorded addresses and the fetch PC hold when no strobe is present.

The arithmetic of the delay-slot step-back, the base-register timing against a same-cycle warm reset, and the priority among overlapping strobes show up only in the bench. The bench drives directed corner cases and seeded random strobe mixes, and compares each output against its own model.

// File: rtl/restart_pkg.sv
package restart_pkg;
  typedef struct packed {
    logic capExc;
    logic capErr;
    logic ldBase;
    logic goBoot;
    logic goResume;
    logic goJump;
  } ctlStrb_t;

  localparam logic signed [31:0] BOOT_LO = 32'shBFC00000;
endpackage

// File: rtl/restart_ctl.sv
module restart_ctl
  import restart_pkg::*;
(
  input  logic     excStrobe,
  input  logic     softRst,
  input  logic     eretStrobe,
  input  logic     jmpStrobe,
  input  logic     baseWe,
  output ctlStrb_t strb
);
  always_comb begin
    strb.capExc   = excStrobe;
    strb.capErr   = softRst;
    strb.ldBase   = baseWe;
    strb.goBoot   = softRst;
    strb.goResume = eretStrobe & ~softRst;
    strb.goJump   = jmpStrobe & ~softRst & ~eretStrobe;
  end
endmodule

// File: rtl/restart_dp.sv
module restart_dp
  import restart_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrb_t      strb,
  input  logic [AW-1:0] pcIn,
  input  logic          dlySlot,
  input  logic          brShort,
  input  logic          isaMode,
  input  logic [AW-1:0] jmpTarget,
  input  logic [AW-1:0] baseData,
  output logic [AW-1:0] restartPc,
  output logic [AW-1:0] errorPc,
  output logic [AW-1:0] fetchPc,
  output logic          modeOut,
  output logic          slotClr
);
  localparam logic [AW-1:0] BOOT_VEC = AW'(BOOT_LO);

  logic [AW-1:0] baseReg;
  logic [AW-1:0] backStep;
  logic [AW-1:0] excAddr;
  logic [AW-1:0] errAddr;

  always_comb begin
    if (!dlySlot)     backStep = '0;
    else if (brShort) backStep = AW'(2);
    else              backStep = AW'(4);
    excAddr = {pcIn[AW-1:1], isaMode} - backStep;
    errAddr = {pcIn[AW-1:1], 1'b0} - backStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg   <= BOOT_VEC;
      restartPc <= '0;
      errorPc   <= '0;
      fetchPc   <= BOOT_VEC;
      modeOut   <= 1'b0;
      slotClr   <= 1'b0;
    end else begin
      if (strb.ldBase) baseReg <= baseData;
      if (strb.capExc) restartPc <= excAddr;
      if (strb.capErr) errorPc <= errAddr;
      slotClr <= strb.goResume;
      if (strb.goBoot) begin
        fetchPc <= {baseReg[AW-1:1], 1'b0};
        modeOut <= 1'b0;
      end else if (strb.goResume) begin
        fetchPc <= {restartPc[AW-1:1], 1'b0};
        modeOut <= restartPc[0];
      end else if (strb.goJump) begin
        fetchPc <= {jmpTarget[AW-1:1], 1'b0};
        modeOut <= jmpTarget[0];
      end
    end
  end
endmodule

// File: rtl/restart_addr_unit.sv
module restart_addr_unit
  import restart_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] pcIn,
  input  logic          dlySlot,
  input  logic          brShort,
  input  logic          isaMode,
  input  logic          excStrobe,
  input  logic          softRst,
  input  logic          eretStrobe,
  input  logic          jmpStrobe,
  input  logic [AW-1:0] jmpTarget,
  input  logic          baseWe,
  input  logic [AW-1:0] baseData,
  output logic [AW-1:0] restartPc,
  output logic [AW-1:0] errorPc,
  output logic [AW-1:0] fetchPc,
  output logic          modeOut,
  output logic          slotClr
);
  ctlStrb_t strb;

  restart_ctl u_ctl (
    .excStrobe (excStrobe),
    .softRst   (softRst),
    .eretStrobe(eretStrobe),
    .jmpStrobe (jmpStrobe),
    .baseWe    (baseWe),
    .strb      (strb)
  );

  restart_dp #(.AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pcIn     (pcIn),
    .dlySlot  (dlySlot),
    .brShort  (brShort),
    .isaMode  (isaMode),
    .jmpTarget(jmpTarget),
    .baseData (baseData),
    .restartPc(restartPc),
    .errorPc  (errorPc),
    .fetchPc  (fetchPc),
    .modeOut  (modeOut),
    .slotClr  (slotClr)
  );
endmodule

// File: rtl/restart_addr_unit_chk.sv
module restart_addr_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          excStrobe,
  input logic          softRst,
  input logic          eretStrobe,
  input logic          jmpStrobe,
  input logic [AW-1:0] jmpTarget,
  input logic [AW-1:0] restartPc,
  input logic [AW-1:0] errorPc,
  input logic [AW-1:0] fetchPc,
  input logic          modeOut,
  input logic          slotClr
);
  p_fetch_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchPc[0] == 1'b0);

  p_jump_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (jmpStrobe && !softRst && !eretStrobe) |=> modeOut == $past(jmpTarget[0]));

  p_boot_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !modeOut);

  p_slot_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eretStrobe && !softRst) |=> slotClr);

  p_slot_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotClr) |-> $past(eretStrobe));

  p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!excStrobe && !softRst) |=> ($stable(restartPc) && $stable(errorPc)));

  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && !eretStrobe && !jmpStrobe) |=> ($stable(fetchPc) && $stable(modeOut)));
endmodule

bind restart_addr_unit restart_addr_unit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .excStrobe (excStrobe),
  .softRst   (softRst),
  .eretStrobe(eretStrobe),
  .jmpStrobe (jmpStrobe),
  .jmpTarget (jmpTarget),
  .restartPc (restartPc),
  .errorPc   (errorPc),
  .fetchPc   (fetchPc),
  .modeOut   (modeOut),
  .slotClr   (slotClr)
);

// File: tb/restart_addr_unit_tb.sv
module restart_addr_unit_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic          dlySlot = 1'b0, brShort = 1'b0, isaMode = 1'b0;
  logic          excStrobe = 1'b0, softRst = 1'b0, eretStrobe = 1'b0, jmpStrobe = 1'b0;
  logic [AW-1:0] jmpTarget = '0;
  logic          baseWe = 1'b0;
  logic [AW-1:0] baseData = '0;
  logic [AW-1:0] restartPc, errorPc, fetchPc;
  logic          modeOut, slotClr;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] mBase, mRestart, mError, mFetch;
  logic          mMode, mSlot;
  string         tagRst, tagErr, tagFetch;

  always #5 clk = ~clk;

  restart_addr_unit #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .dlySlot(dlySlot), .brShort(brShort),
    .isaMode(isaMode), .excStrobe(excStrobe), .softRst(softRst),
    .eretStrobe(eretStrobe), .jmpStrobe(jmpStrobe), .jmpTarget(jmpTarget),
    .baseWe(baseWe), .baseData(baseData), .restartPc(restartPc),
    .errorPc(errorPc), .fetchPc(fetchPc), .modeOut(modeOut), .slotClr(slotClr)
  );

  function automatic logic [AW-1:0] stepOf(logic s, logic sh);
    return !s ? '0 : (sh ? AW'(2) : AW'(4));
  endfunction

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk(tagRst, "restartPc", restartPc, mRestart);
    chk(tagErr, "errorPc", errorPc, mError);
    chk(tagFetch, "fetchPc", fetchPc, mFetch);
    chk(tagFetch, "modeOut", AW'(modeOut), AW'(mMode));
    chk("R8", "slotClr", AW'(slotClr), AW'(mSlot));
  endtask

  // One clock: model update from driven inputs, then compare after the edge.
  task automatic step();
    logic [AW-1:0] oldRestart, oldBase;
    oldRestart = mRestart;
    oldBase = mBase;
    tagRst = "R4"; tagErr = "R4"; tagFetch = "R9";
    if (baseWe) mBase = baseData;
    if (excStrobe) begin
      mRestart = {pcIn[AW-1:1], isaMode} - stepOf(dlySlot, brShort);
      tagRst = dlySlot ? "R3" : "R2";
    end
    if (softRst) begin
      mError = {pcIn[AW-1:1], 1'b0} - stepOf(dlySlot, brShort);
      tagErr = "R5";
    end
    mSlot = eretStrobe && !softRst;
    if (softRst) begin
      mFetch = {oldBase[AW-1:1], 1'b0}; mMode = 1'b0; tagFetch = baseWe ? "R6" : "R5";
    end else if (eretStrobe) begin
      mFetch = {oldRestart[AW-1:1], 1'b0}; mMode = oldRestart[0]; tagFetch = "R8";
    end else if (jmpStrobe) begin
      mFetch = {jmpTarget[AW-1:1], 1'b0}; mMode = jmpTarget[0]; tagFetch = "R7";
    end
    @(posedge clk);
    #2;
    compareAll();
    excStrobe = 0; softRst = 0; eretStrobe = 0; jmpStrobe = 0; baseWe = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    mBase = 32'hBFC00000; mFetch = 32'hBFC00000;
    mRestart = '0; mError = '0; mMode = 0; mSlot = 0;
    tagRst = "R1"; tagErr = "R1"; tagFetch = "R1";
    #23;
    compareAll();             // R1 while in reset
    rstN = 1'b1;
    @(posedge clk); #2;
    compareAll();             // R1 after release

    // R2: no slot, mode 1, odd pc bit ignored
    pcIn = 32'h0000_1235; isaMode = 1; dlySlot = 0; brShort = 1; excStrobe = 1; step();
    // R3: slot with 16-bit branch, mode 1 -> 0x0FF
    pcIn = 32'h0000_0100; isaMode = 1; dlySlot = 1; brShort = 1; excStrobe = 1; step();
    // R3: slot with 32-bit branch, mode 0 -> 0x0FC
    pcIn = 32'h0000_0100; isaMode = 0; dlySlot = 1; brShort = 0; excStrobe = 1; step();
    // R8: resume from 0x0FC; then exception and resume in one cycle (old value used)
    eretStrobe = 1; step();
    step();
    pcIn = 32'h0000_2000; isaMode = 1; dlySlot = 0; excStrobe = 1; eretStrobe = 1; step();
    // R7: jump to odd target enters compressed mode
    jmpTarget = 32'h8000_0011; jmpStrobe = 1; step();
    // R6: base write then warm reset; then write coinciding with warm reset
    baseData = 32'h9000_0000; baseWe = 1; step();
    pcIn = 32'h0000_0400; dlySlot = 1; brShort = 0; softRst = 1; step();
    baseData = 32'hA000_0000; baseWe = 1; softRst = 1; jmpStrobe = 1; eretStrobe = 1; step();
    // R9: priority eret over jump
    eretStrobe = 1; jmpStrobe = 1; jmpTarget = 32'h1234_5679; step();
    step();

    for (int i = 0; i < 3000; i++) begin
      pcIn       = $urandom;
      dlySlot    = $urandom_range(0, 1);
      brShort    = $urandom_range(0, 1);
      isaMode    = $urandom_range(0, 1);
      excStrobe  = ($urandom_range(0, 3) == 0);
      softRst    = ($urandom_range(0, 9) == 0);
      eretStrobe = ($urandom_range(0, 5) == 0);
      jmpStrobe  = ($urandom_range(0, 3) == 0);
      jmpTarget  = $urandom;
      baseWe     = ($urandom_range(0, 7) == 0);
      baseData   = $urandom;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule